// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master of a network subsystem. It generates the management clock (MDC) from the system clock and shifts complete management frames on the shared bidirectional data line (MDIO). These frames reach registers inside external PHY devices. Both the direct-addressed frame format of clause 22 and the indirect, device-addressed format of clause 45 are produced. A mode bit selects which one is used. The same mode bit also sets how the command opcode is decoded.

Software drives the block through five word-aligned registers:

| Register | Offset |
|---|---|
| Command | 0x00 |
| Write payload | 0x08 |
| Read result | 0x10 |
| Clock and mode | 0x18 |
| Enable | 0x20 |

A write to the command register starts exactly one frame. The payload for writes and for clause 45 address cycles comes from the write payload register. Software then polls the pending flags until the frame is done. For a read, it also polls the valid flag.

Top module: `mdio_master`

## Requirements
- R1: After reset the block is as follows:
  - MDC and the MDIO output enable are low.
  - The enable register (bit 0 at 0x20) reads 0.
  - The write payload and read result registers read 0.
  - The clock and mode register at 0x18 reads the divider reset value in bits [7:0], clause 22 mode (bit 8 = 0) and preamble on (bit 9 = 1).
- R2: While enable bit 0 at 0x20 is 0:
  - A command write starts no frame and sets no flag.
  - MDC stays low and MDIO is not driven.
  - Clearing enable during a frame aborts it within one cycle and clears the pending flags.
- R3: A clause 22 write is command opcode 0. The command register fields are register number in bits [4:0], PHY address in bits [12:8] and opcode in bits [17:16]. The frame is sent MSB first as: 32 ones (preamble), start 01, op 01, PHY address, register, turnaround 10, then the 16 payload bits from bits [15:0] of 0x08.
- R4: A clause 22 read is command opcode 1. It sends start 01 and op 10, then releases MDIO from the first turnaround bit to the end of the frame. It shifts in 16 data bits, MSB first. The result appears in bits [15:0] of 0x10 with the valid flag (bit 30) set.
- R5: In clause 45 mode (bit 8 of 0x18 = 1), command opcode 0 sends an address frame. The frame carries start 00 and op 00. The register field of the command carries the device address. The payload is the 16-bit register address from 0x08, preceded by turnaround 10.
- R6: In clause 45 mode, command opcode 1 sends a write frame (op 01, payload from 0x08). Command opcode 3 sends a read frame (op 11), which returns data as in R4.
- R7: With the preamble bit (bit 9 of 0x18) at 0, a frame has no preamble and is 32 MDC periods long.
- R8: MDC has a period of 2*(D+1) system clocks, where D is bits [7:0] of 0x18. MDIO output changes only as MDC falls, and read data is sampled as MDC rises.
- R9: Pending flags are bit 31 of the register they belong to:
  - The write payload pending flag is 1 from the cycle after a write or address command until the frame has shifted out.
  - The read result pending flag does the same for reads.
  - Starting a read clears the valid flag.
- R10: If MDIO is not low at the rising MDC edge of the second turnaround bit of a read, the read completes with the valid flag at 0.
- R11: A command written while either pending flag is 1 is ignored. Rewriting 0x08 during a frame does not change the frame in flight.
- R12: Unsupported opcodes start nothing and set no flag. These are opcodes 2 and 3 in clause 22 mode, and opcode 2 in clause 45 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from csr_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Register writes from software and frame shifting by the engine can fall in the same cycle. Two collisions are provoked on purpose, both while a write frame is shifting:
- The write payload register is rewritten.
- A second command, a read to a different PHY, is issued.

Every bit on the wire is captured at rising MDC edges and compared with a frame computed from the first command alone. The read pending flag is also checked to confirm it never rose.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int unsigned CSR_AW   = 6;
    localparam int unsigned CSR_DW   = 32;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned PA_W     = 5;
    localparam int unsigned PRE_W    = 32;
    localparam int unsigned HDR_W    = 2 + 2 + PA_W + PA_W;
    localparam int unsigned FRAME_W  = PRE_W + HDR_W + 2 + DATA_W;
    localparam int unsigned IDX_W    = $clog2(FRAME_W + 1);
    localparam int unsigned TA_POS   = PRE_W + HDR_W;
    localparam int unsigned DATA_POS = TA_POS + 2;

    localparam logic [CSR_AW-1:0] OFF_CMD   = 6'h00;
    localparam logic [CSR_AW-1:0] OFF_WDATA = 6'h08;
    localparam logic [CSR_AW-1:0] OFF_RDATA = 6'h10;
    localparam logic [CSR_AW-1:0] OFF_CTRL  = 6'h18;
    localparam logic [CSR_AW-1:0] OFF_EN    = 6'h20;

    localparam int unsigned CMD_REG_LSB = 0;
    localparam int unsigned CMD_PHY_LSB = 8;
    localparam int unsigned CMD_OP_LSB  = 16;
    localparam int unsigned PEND_BIT    = 31;
    localparam int unsigned VALID_BIT   = 30;
    localparam int unsigned MODE_BIT    = 8;
    localparam int unsigned PRE_BIT     = 9;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e       kind;
        logic              c45;
        logic              preamble;
        logic [PA_W-1:0]   phy;
        logic [PA_W-1:0]   regf;
        logic [DATA_W-1:0] payload;
    } frame_req_t;

    function automatic logic op_supported(input logic c45, input logic [1:0] op);
        if (c45) return (op != 2'd2);
        return (op == 2'd0) || (op == 2'd1);
    endfunction

    function automatic frame_kind_e op_kind(input logic c45, input logic [1:0] op);
        if (c45) begin
            case (op)
                2'd0:    return FK_ADDR;
                2'd1:    return FK_WRITE;
                default: return FK_READ;
            endcase
        end
        return (op == 2'd1) ? FK_READ : FK_WRITE;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input frame_req_t r);
        logic [1:0] st;
        logic [1:0] wop;
        logic [1:0] ta;
        logic [DATA_W-1:0] dat;
        st = r.c45 ? 2'b00 : 2'b01;
        case (r.kind)
            FK_ADDR:  wop = 2'b00;
            FK_WRITE: wop = 2'b01;
            default:  wop = r.c45 ? 2'b11 : 2'b10;
        endcase
        ta  = (r.kind == FK_READ) ? 2'b11 : 2'b10;
        dat = (r.kind == FK_READ) ? {DATA_W{1'b1}} : r.payload;
        return {{PRE_W{1'b1}}, st, wop, r.phy, r.regf, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              is_read,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic               busy_q;
    logic               rd_q;
    logic               mdc_q;
    logic               ack_q;
    logic [FRAME_W-1:0] sh_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  rx_q;
    logic               valid_q;
    logic [DATA_W-1:0]  data_q;
    logic [FRAME_W-1:0] frame_w;

    assign frame_w = build_frame(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            mdc_q   <= 1'b0;
            ack_q   <= 1'b0;
            sh_q    <= '0;
            idx_q   <= '0;
            rx_q    <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
            mdc_q  <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            rd_q    <= (req.kind == FK_READ);
            mdc_q   <= 1'b0;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            if (req.preamble) begin
                sh_q  <= frame_w;
                idx_q <= '0;
            end else begin
                sh_q  <= frame_w << PRE_W;
                idx_q <= IDX_W'(PRE_W);
            end
        end else if (busy_q && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (rd_q && (idx_q == IDX_W'(TA_POS + 1))) begin
                    ack_q <= !mdio_i;
                end
                if (rd_q && (idx_q >= IDX_W'(DATA_POS))) begin
                    rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                end
            end else begin
                mdc_q <= 1'b0;
                sh_q  <= sh_q << 1;
                if (idx_q == IDX_W'(FRAME_W - 1)) begin
                    busy_q <= 1'b0;
                    if (rd_q) begin
                        valid_q <= ack_q;
                        data_q  <= rx_q;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign is_read  = rd_q;
    assign mdc      = mdc_q;
    assign mdio_o   = busy_q && sh_q[FRAME_W-1];
    assign mdio_oe  = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));
    assign rd_valid = valid_q;
    assign rd_data  = data_q;

    // R8: the driven line moves only together with a falling MDC
    a_r8_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc_q));

    // R2: disabled block leaves MDC low and MDIO released
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!mdc && !mdio_oe));

    // R9: a frame that runs to its end retires on a falling MDC
    a_r9_ends_on_fall: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && $past(en)) |-> $fell(mdc_q));

    // R10: valid may only rise after the PHY acknowledged in turnaround
    a_r10_valid_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> ($past(ack_q) && $past(rd_q)));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int unsigned     DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              busy,
    input  logic              is_read,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output frame_req_t        req,
    output logic              en,
    output logic [DIV_W-1:0]  div
);
    logic [DATA_W-1:0] wpay_q;
    logic [DIV_W-1:0]  div_q;
    logic              c45_q;
    logic              pre_q;
    logic              en_q;
    logic [1:0]        op_w;
    logic              cmd_wr;
    logic              wr_pend;
    logic              rd_pend;

    assign op_w   = csr_wdata[CMD_OP_LSB +: 2];
    assign cmd_wr = csr_we && (csr_addr == OFF_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            wpay_q <= '0;
            div_q  <= DIV_RESET;
            c45_q  <= 1'b0;
            pre_q  <= 1'b1;
            en_q   <= 1'b0;
        end else if (csr_we) begin
            case (csr_addr)
                OFF_WDATA: wpay_q <= csr_wdata[DATA_W-1:0];
                OFF_CTRL: begin
                    div_q <= csr_wdata[DIV_W-1:0];
                    c45_q <= csr_wdata[MODE_BIT];
                    pre_q <= csr_wdata[PRE_BIT];
                end
                OFF_EN:  en_q <= csr_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        req.kind     = op_kind(c45_q, op_w);
        req.c45      = c45_q;
        req.preamble = pre_q;
        req.phy      = csr_wdata[CMD_PHY_LSB +: PA_W];
        req.regf     = csr_wdata[CMD_REG_LSB +: PA_W];
        req.payload  = wpay_q;
    end

    assign start   = cmd_wr && en_q && !busy && op_supported(c45_q, op_w);
    assign wr_pend = busy && !is_read;
    assign rd_pend = busy && is_read;
    assign en      = en_q;
    assign div     = div_q;

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFF_WDATA: begin
                csr_rdata[DATA_W-1:0] = wpay_q;
                csr_rdata[PEND_BIT]   = wr_pend;
            end
            OFF_RDATA: begin
                csr_rdata[DATA_W-1:0] = rd_data;
                csr_rdata[VALID_BIT]  = rd_valid;
                csr_rdata[PEND_BIT]   = rd_pend;
            end
            OFF_CTRL: begin
                csr_rdata[DIV_W-1:0] = div_q;
                csr_rdata[MODE_BIT]  = c45_q;
                csr_rdata[PRE_BIT]   = pre_q;
            end
            OFF_EN:  csr_rdata[0] = en_q;
            default: csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned      DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              start;
    frame_req_t        req;
    logic              en;
    logic [DIV_W-1:0]  div;
    logic              tick;
    logic              busy;
    logic              is_read;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;

    mdio_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .busy(busy), .is_read(is_read), .rd_valid(rd_valid), .rd_data(rd_data),
        .start(start), .req(req), .en(en), .div(div)
    );

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .en(en), .start(start), .req(req), .tick(tick),
        .mdio_i(mdio_i), .busy(busy), .is_read(is_read), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #2 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // PHY model state
    logic        phy_val = 1'b1;
    logic        phy_ack = 1'b1;
    logic [15:0] phy_data = '0;
    bit          phy_reading = 0;
    int          off = 0;
    logic [63:0] cap = '0;
    int          ncap = 0;
    realtime     prev_rise = 0;
    realtime     last_period = 0;

    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_i};
        ncap++;
        last_period = $realtime - prev_rise;
        prev_rise = $realtime;
    end

    always @(negedge mdc) begin
        int pos;
        pos = off + ncap;
        if (phy_reading && phy_ack && pos == 47) phy_val = 1'b0;
        else if (phy_reading && phy_ack && pos >= 48 && pos <= 63) phy_val = phy_data[63 - pos];
        else phy_val = 1'b1;
    end

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_idle(input string r);
        logic [31:0] w, q;
        int n = 0;
        do begin
            rd(6'h08, w);
            rd(6'h10, q);
            n++;
        end while ((w[31] || q[31]) && n < 5000);
        chk({r, " frame completes"}, n < 5000, 1);
    endtask

    function automatic logic [63:0] exp_frame(input bit c45, input int op, input logic [4:0] phy,
            input logic [4:0] rg, input logic [15:0] pay, input bit ack);
        logic [1:0] st, o, ta;
        logic [15:0] d;
        bit rdop;
        st = c45 ? 2'b00 : 2'b01;
        rdop = c45 ? (op == 3) : (op == 1);
        if (c45) o = (op == 0) ? 2'b00 : (op == 1) ? 2'b01 : 2'b11;
        else     o = (op == 0) ? 2'b01 : 2'b10;
        ta = rdop ? {1'b1, !ack} : 2'b10;
        d  = rdop ? (ack ? phy_data : 16'hFFFF) : pay;
        return {32'hFFFF_FFFF, st, o, phy, rg, ta, d};
    endfunction

    // One complete frame, checked on the wire and in the flags
    task automatic run(input string r, input bit c45, input int op, input logic [4:0] phy,
            input logic [4:0] rg, input logic [15:0] pay, input bit pre, input bit ack);
        logic [31:0] v;
        logic [63:0] e;
        bit rdop;
        rdop = c45 ? (op == 3) : (op == 1);
        phy_ack = ack; phy_reading = rdop; off = pre ? 0 : 32;
        cap = '0; ncap = 0;
        if (!rdop) wr(6'h08, {16'h0, pay});
        wr(6'h00, {14'h0, op[1:0], 3'h0, phy, 3'h0, rg});
        rd(rdop ? 6'h10 : 6'h08, v);
        chk({r, "/R9 pending set"}, v[31], 1);
        if (rdop) chk({r, "/R9 valid cleared at start"}, v[30], 0);
        wait_idle(r);
        e = exp_frame(c45, op, phy, rg, pay, ack);
        chk({r, " bit count"}, ncap, pre ? 64 : 32);
        if (pre) chk({r, " wire frame"}, cap, e);
        else     chk({r, " wire frame"}, {32'h0, cap[31:0]}, {32'h0, e[31:0]});
        if (rdop) begin
            rd(6'h10, v);
            chk({r, " read valid"}, v[30], ack);
            if (ack) chk({r, " read data"}, v[15:0], phy_data);
        end
        phy_reading = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h18, v); chk("R1 ctrl", v, 32'h0000_0209);
        rd(6'h20, v); chk("R1 enable", v, 0);
        rd(6'h08, v); chk("R1 wdata", v, 0);
        rd(6'h10, v); chk("R1 rdata", v, 0);
        chk("R1 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        ncap = 0;
        wr(6'h00, 32'h0000_0501);
        repeat (60) @(negedge clk);
        chk("R2 no mdc while disabled", ncap, 0);
        rd(6'h08, v); chk("R2 no pending while disabled", v[31], 0);
        wr(6'h20, 1);
        wr(6'h18, 32'h0000_0201);
        wr(6'h08, 32'h0000_1234);
        wr(6'h00, 32'h0000_0501);
        repeat (30) @(negedge clk);
        wr(6'h20, 0);
        repeat (3) @(negedge clk);
        chk("R2 abort mdc low, released", {mdc, mdio_oe}, 0);
        rd(6'h08, v); chk("R2 abort clears pending", v[31], 0);
        wr(6'h20, 1);
    endtask

    task automatic t_busy_collision();
        logic [31:0] v;
        logic [63:0] e;
        phy_reading = 0; off = 0; cap = '0; ncap = 0;
        wr(6'h08, 32'h0000_1111);
        wr(6'h00, 32'h0000_0501);
        repeat (20) @(negedge clk);
        wr(6'h08, 32'h0000_2222);
        wr(6'h00, 32'h0001_0902);
        rd(6'h10, v); chk("R11 second command ignored", v[31], 0);
        rd(6'h08, v); chk("R11 first frame still pending", v[31], 1);
        wait_idle("R11");
        e = exp_frame(0, 0, 5'd5, 5'd1, 16'h1111, 1);
        chk("R11 frame unaffected", cap, e);
    endtask

    task automatic t_bad_op(input bit c45, input logic [1:0] op);
        logic [31:0] v;
        wr(6'h18, {22'h0, 1'b1, c45, 8'd1});
        ncap = 0;
        wr(6'h00, {14'h0, op, 16'h0301});
        repeat (20) @(negedge clk);
        rd(6'h08, v); chk("R12 no write pending", v[31], 0);
        rd(6'h10, v); chk("R12 no read pending", v[31], 0);
        chk("R12 no mdc", ncap, 0);
    endtask

    task automatic t_period();
        wr(6'h18, 32'h0000_0203);
        run("R8 div3", 0, 0, 5'd2, 5'd4, 16'h0F0F, 1, 1);
        chk("R8 mdc period ns", 64'(int'(last_period)), 32);
    endtask

    initial begin
        #600000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        wr(6'h18, 32'h0000_0201);
        run("R3 c22 write", 0, 0, 5'd5, 5'd26, 16'hBEEF, 1, 1);
        phy_data = 16'h1234;
        run("R4 c22 read", 0, 1, 5'd3, 5'd2, 16'h0, 1, 1);
        wr(6'h18, 32'h0000_0301);
        run("R5 c45 address", 1, 0, 5'd1, 5'd7, 16'h8001, 1, 1);
        run("R6 c45 write", 1, 1, 5'd1, 5'd7, 16'h55AA, 1, 1);
        phy_data = 16'hC3C3;
        run("R6 c45 read", 1, 3, 5'd1, 5'd7, 16'h0, 1, 1);
        wr(6'h18, 32'h0000_0001);
        run("R7 no preamble", 0, 0, 5'd30, 5'd17, 16'hA5C3, 0, 1);
        wr(6'h18, 32'h0000_0201);
        run("R10 no ack", 0, 1, 5'd4, 5'd9, 16'h0, 1, 0);
        t_busy_collision();
        t_bad_op(0, 2'd2);
        t_bad_op(0, 2'd3);
        t_bad_op(1, 2'd2);
        t_period();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule